// File: doc/BRIEF.md
# Audio Frame Clock Error Monitor

This block watches the bit clock and frame sync of a TDM or I2S audio serial port, sampling both against the system clock. It flags three kinds of fault. The first is a bits-per-frame count that is not a supported ratio. The second is a frame period, measured in system clocks, that lies outside a programmable window. The third is a stall, meaning either line has stopped toggling.

While a fault is present the block drives a live error flag to the interrupt logic. It also mutes the record path through a gain multiplier that the data path applies to every sample. When the clocks are healthy again, the gain climbs back in equal steps, one step per frame, until it reaches the host's volume setting.

Both serial lines are asynchronous to the system clock and are synchronized inside the block. The block never handles sample data.

Top module: `afc_clk_monitor`

## Requirements
- R1: After reset, gain_o is 0 and clk_err_o is 0. The record path starts muted and must earn its way up.
- R2: At each frame sync rising edge the block counts the bit clock rising edges in the frame just ended. A count other than 32, 64, 128, 256 or 512 is an error.
- R3: The frame period is the number of system clocks between two frame sync rising edges. A period below per_min_i or above per_max_i is an error. Both limits are inclusive.
- R4: A stall is flagged when the bit clock or the frame sync shows no edge for STALL_CYC (4096) system clocks. While the stall lasts, clk_err_o is 1 and gain_o is 0.
- R5: A frame that fails R2 or R3 forces gain_o to 0 as soon as that frame closes. clk_err_o then stays 1 until a later frame is judged clean.
- R6: Gain rises only after two consecutive clean frames. It rises by STEP (1/64 of full scale, 16 at GAIN_W=10) at the close of each clean frame from the second onward.
- R7: A ramp step never exceeds gain_target_i. If gain_target_i has been lowered below the current gain, the next step sets gain_o equal to gain_target_i.
- R8: The first frame sync rising edge after reset arms the frame meter and is not judged. After a stall, the edge that ends the stall is ignored, and the edge after that arms the meter.
- R9: clk_err_o returns to 0 as soon as a frame is judged clean and no stall is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| fsync_i | input | 1 | Frame sync, asynchronous |
| per_min_i | input | PER_W | Shortest allowed frame period in system clocks |
| per_max_i | input | PER_W | Longest allowed frame period in system clocks |
| gain_target_i | input | GAIN_W | Volume setting that the recovery ramp climbs to |
| clk_err_o | output | 1 | Live clock error flag |
| gain_o | output | GAIN_W | Gain multiplier for the record path |

## Verification
Suppose the bit counter or the period counter goes wrong. A good frame would then be judged bad, so gain_o falls to 0 and clk_err_o rises one frame after the faulty frame. The reverse error, a bad frame passing, shows as a missing mute one frame after that frame.

A wrong clean-frame flag or a wrong ramp adder shows up at the next frame boundary, as a gain one STEP off or a ramp that starts one frame early or late. Errors in the stall counter show only after thousands of quiet cycles. The bench therefore probes a quiet gap both before and after the timeout.

// File: rtl/afc_pkg.sv
package afc_pkg;
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } edge_t;

  localparam int unsigned LINE_BCLK  = 0;
  localparam int unsigned LINE_FSYNC = 1;
  localparam int unsigned NUM_LINES  = 2;
endpackage

// File: rtl/afc_edge_sync.sv
module afc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           async_i,
  output afc_pkg::edge_t edge_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign edge_o.lvl  = sh_q[STAGES-1];
  assign edge_o.rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign edge_o.fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/afc_stall_mon.sv
module afc_stall_mon #(
  parameter int unsigned LIMIT     = 4096,
  parameter int unsigned NUM_LINES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] act_i,
  output logic [NUM_LINES-1:0] stall_line_o,
  output logic                 stall_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [CW-1:0] idle_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    idle_q <= '0;
      else if (act_i[g])              idle_q <= '0;
      else if (idle_q != CW'(LIMIT))  idle_q <= idle_q + 1'b1;
    end
    assign stall_line_o[g] = (idle_q == CW'(LIMIT));
  end

  assign stall_o = |stall_line_o;
endmodule

// File: rtl/afc_frame_meter.sv
module afc_frame_meter #(
  parameter int unsigned PER_W        = 16,
  parameter int unsigned RATIO_MIN_LG = 5,
  parameter int unsigned RATIO_MAX_LG = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_rise_i,
  input  logic             fs_rise_i,
  input  logic             stall_i,
  input  logic [PER_W-1:0] per_min_i,
  input  logic [PER_W-1:0] per_max_i,
  output logic             eval_o,
  output logic             bad_o
);
  localparam int unsigned CNT_W = RATIO_MAX_LG + 2;
  localparam int unsigned NR    = RATIO_MAX_LG - RATIO_MIN_LG + 1;

  logic [CNT_W-1:0] bcnt_q;
  logic [PER_W-1:0] pcnt_q;
  logic             armed_q, eval_q, bad_q;
  logic [NR-1:0]    ratio_hit;
  logic             ratio_ok, per_ok;

  for (genvar k = 0; k < NR; k++) begin : g_ratio
    assign ratio_hit[k] = (bcnt_q == CNT_W'(1 << (RATIO_MIN_LG + k)));
  end

  assign ratio_ok = |ratio_hit;
  assign per_ok   = (pcnt_q >= per_min_i) && (pcnt_q <= per_max_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q  <= '0;
      pcnt_q  <= '0;
      armed_q <= 1'b0;
      eval_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      eval_q <= 1'b0;
      if (stall_i) begin
        armed_q <= 1'b0;
        bad_q   <= 1'b0;
      end else if (fs_rise_i) begin
        armed_q <= 1'b1;
        if (armed_q) begin
          eval_q <= 1'b1;
          bad_q  <= ~(ratio_ok & per_ok);
        end
      end
      if (fs_rise_i) begin
        // a coincident bit clock edge opens the new frame
        bcnt_q <= CNT_W'(bclk_rise_i);
        pcnt_q <= PER_W'(1);
      end else begin
        if (bclk_rise_i && (bcnt_q != '1)) bcnt_q <= bcnt_q + 1'b1;
        if (pcnt_q != '1)                  pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end

  assign eval_o = eval_q;
  assign bad_o  = bad_q;
endmodule

// File: rtl/afc_gain_ramp.sv
module afc_gain_ramp #(
  parameter int unsigned GAIN_W  = 10,
  parameter int unsigned STEP_LG = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eval_i,
  input  logic              bad_i,
  input  logic              stall_i,
  input  logic [GAIN_W-1:0] target_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam int unsigned STEP = 1 << (GAIN_W - STEP_LG);

  logic [GAIN_W-1:0] gain_q, ramp_next;
  logic [GAIN_W:0]   sum;
  logic              clean_q;

  assign sum       = {1'b0, gain_q} + (GAIN_W + 1)'(STEP);
  assign ramp_next = (sum > {1'b0, target_i}) ? target_i : sum[GAIN_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q  <= '0;
      clean_q <= 1'b0;
    end else if (stall_i) begin
      gain_q  <= '0;
      clean_q <= 1'b0;
    end else if (eval_i) begin
      if (bad_i) begin
        gain_q  <= '0;
        clean_q <= 1'b0;
      end else begin
        // second clean frame in a row and onward
        if (clean_q) gain_q <= ramp_next;
        clean_q <= 1'b1;
      end
    end
  end

  assign gain_o = gain_q;
endmodule

// File: rtl/afc_clk_monitor.sv
module afc_clk_monitor #(
  parameter int unsigned PER_W        = 16,
  parameter int unsigned GAIN_W       = 10,
  parameter int unsigned STEP_LG      = 6,
  parameter int unsigned STALL_CYC    = 4096,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned RATIO_MIN_LG = 5,
  parameter int unsigned RATIO_MAX_LG = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic [PER_W-1:0]  per_min_i,
  input  logic [PER_W-1:0]  per_max_i,
  input  logic [GAIN_W-1:0] gain_target_i,
  output logic              clk_err_o,
  output logic [GAIN_W-1:0] gain_o
);
  import afc_pkg::*;

  logic [NUM_LINES-1:0] raw, act, stall_line;
  edge_t                ev [NUM_LINES];
  logic                 stall_any, frame_eval, frame_bad;

  assign raw[LINE_BCLK]  = bclk_i;
  assign raw[LINE_FSYNC] = fsync_i;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
    afc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(raw[g]),
      .edge_o (ev[g])
    );
    assign act[g] = ev[g].rise | ev[g].fall;
  end

  afc_stall_mon #(.LIMIT(STALL_CYC), .NUM_LINES(NUM_LINES)) u_stall (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act),
    .stall_line_o(stall_line),
    .stall_o     (stall_any)
  );

  afc_frame_meter #(
    .PER_W(PER_W), .RATIO_MIN_LG(RATIO_MIN_LG), .RATIO_MAX_LG(RATIO_MAX_LG)
  ) u_meter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bclk_rise_i(ev[LINE_BCLK].rise),
    .fs_rise_i  (ev[LINE_FSYNC].rise),
    .stall_i    (stall_any),
    .per_min_i  (per_min_i),
    .per_max_i  (per_max_i),
    .eval_o     (frame_eval),
    .bad_o      (frame_bad)
  );

  afc_gain_ramp #(.GAIN_W(GAIN_W), .STEP_LG(STEP_LG)) u_ramp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .eval_i  (frame_eval),
    .bad_i   (frame_bad),
    .stall_i (stall_any),
    .target_i(gain_target_i),
    .gain_o  (gain_o)
  );

  assign clk_err_o = frame_bad | stall_any;
endmodule

// File: rtl/afc_clk_monitor_chk.sv
module afc_clk_monitor_chk #(
  parameter int unsigned GAIN_W  = 10,
  parameter int unsigned STEP_LG = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clk_err_o,
  input logic [GAIN_W-1:0] gain_o,
  input logic [GAIN_W-1:0] gain_target_i,
  input logic              stall_i,
  input logic              eval_i,
  input logic              bad_i
);
  localparam int unsigned STEP = 1 << (GAIN_W - STEP_LG);

  // R6
  gain_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_o > $past(gain_o)) |-> ((gain_o - $past(gain_o)) <= GAIN_W'(STEP)));

  // R7
  gain_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_o > $past(gain_o)) |-> (gain_o <= $past(gain_target_i)));

  // R5
  mute_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_err_o |=> (gain_o <= $past(gain_o)));

  // R4
  stall_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> (gain_o == '0));

  // R2 R3
  bad_frame_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && bad_i) |=> (gain_o == '0));
endmodule

bind afc_clk_monitor afc_clk_monitor_chk #(.GAIN_W(GAIN_W), .STEP_LG(STEP_LG)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clk_err_o    (clk_err_o),
  .gain_o       (gain_o),
  .gain_target_i(gain_target_i),
  .stall_i      (stall_any),
  .eval_i       (frame_eval),
  .bad_i        (frame_bad)
);

// File: tb/afc_clk_monitor_tb.sv
module afc_clk_monitor_tb;
  localparam int PER_W  = 16;
  localparam int GAIN_W = 10;
  localparam int STEP   = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bclk = 1'b1;
  logic              fsync = 1'b0;
  logic [PER_W-1:0]  per_min = 16'd128;
  logic [PER_W-1:0]  per_max = 16'd512;
  logic [GAIN_W-1:0] target = 10'd200;
  logic              clk_err;
  logic [GAIN_W-1:0] gain;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  bit m_armed = 1'b0, m_stalled = 1'b0, m_clean = 1'b0, m_bad = 1'b0;
  int m_gain = 0;
  int prev_n = 0, prev_h = 0;

  always #10 clk = ~clk;

  afc_clk_monitor u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bclk_i       (bclk),
    .fsync_i      (fsync),
    .per_min_i    (per_min),
    .per_max_i    (per_max),
    .gain_target_i(target),
    .clk_err_o    (clk_err),
    .gain_o       (gain)
  );

  function automatic bit ratio_ok(int n);
    return (n == 32) || (n == 64) || (n == 128) || (n == 256) || (n == 512);
  endfunction

  function automatic bit frame_good(int n, int h);
    int per = 2 * h * n;
    return ratio_ok(n) && (per >= int'(per_min)) && (per <= int'(per_max));
  endfunction

  function automatic int ramp(int g, int t);
    return (g + STEP > t) ? t : g + STEP;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // model step at a frame sync rising edge
  task automatic model_edge();
    if (m_stalled) m_stalled = 1'b0;
    else if (!m_armed) m_armed = 1'b1;
    else begin
      if (!frame_good(prev_n, prev_h)) begin
        m_bad = 1'b1; m_gain = 0; m_clean = 1'b0;
      end else begin
        m_bad = 1'b0;
        if (m_clean) m_gain = ramp(m_gain, int'(target));
        m_clean = 1'b1;
      end
    end
  endtask

  task automatic send_frame(int n, int h, string tag);
    model_edge();
    for (int i = 0; i < n; i++) begin
      bclk = 1'b0;
      if (i == 0) fsync = 1'b1;
      if (i == n / 2) fsync = 1'b0;
      wait_clk(h);
      if (i == n / 2) begin
        chk({tag, " gain"}, int'(gain), m_gain);
        chk({tag, " err"}, int'(clk_err), int'(m_bad));
      end
      bclk = 1'b1;
      wait_clk(h);
    end
    prev_n = n;
    prev_h = h;
  endtask

  task automatic stall_gap();
    wait_clk(3500);
    chk("R4 before timeout gain", int'(gain), m_gain);
    chk("R4 before timeout err", int'(clk_err), int'(m_bad));
    wait_clk(1500);
    chk("R4 stalled gain", int'(gain), 0);
    chk("R4 stalled err", int'(clk_err), 1);
    m_stalled = 1'b1; m_armed = 1'b0; m_bad = 1'b0; m_gain = 0; m_clean = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0A1C);
    wait_clk(5);
    chk("R1 reset gain", int'(gain), 0);
    chk("R1 reset err", int'(clk_err), 0);
    rst_n = 1'b1;
    wait_clk(3);
    chk("R1 after release gain", int'(gain), 0);

    // R8 first edge only arms; R6 ramp to target, R7 clamp at 200
    for (int f = 0; f < 18; f++) send_frame(64, 2, "R6 ramp");

    // R2 ratio error then R9/R6 recovery
    send_frame(48, 2, "R2 pre");
    send_frame(64, 2, "R2 R5 mute after bad ratio");
    send_frame(64, 2, "R9 first clean");
    send_frame(64, 2, "R6 second clean");
    send_frame(64, 2, "R6 ramping");

    // R3 period error and inclusive bounds
    send_frame(256, 2, "R3 pre");
    send_frame(32, 2, "R3 R5 long period mute");
    send_frame(32, 2, "R3 low bound 128");
    send_frame(128, 2, "R3 high bound 512");
    send_frame(128, 2, "R3 high bound again");
    send_frame(16, 8, "R2 pre low ratio");
    send_frame(64, 2, "R2 ratio 16 rejected");
    for (int f = 0; f < 16; f++) send_frame(64, 2, "R6 recover");

    // R7 lower the target
    target = 10'd100;
    send_frame(64, 2, "R7 pre");
    send_frame(64, 2, "R7 lowered target");

    // R2 extreme ratios with wide window
    per_max = 16'd5000;
    send_frame(512, 2, "R2 ratio 512");
    send_frame(1024, 2, "R2 ratio 512 accepted");
    send_frame(64, 2, "R2 ratio 1024 rejected");
    per_max = 16'd512;
    for (int f = 0; f < 3; f++) send_frame(64, 2, "R6 back");

    // R4 stall and R8 re-arming
    stall_gap();
    send_frame(64, 2, "R8 stall end edge");
    send_frame(64, 2, "R8 arming edge");
    send_frame(64, 2, "R8 first judged");
    send_frame(64, 2, "R8 R6 second judged");
    send_frame(64, 2, "R6 after stall");

    // random frames
    for (int f = 0; f < 40; f++) begin
      int pick, sizes[6];
      sizes = '{32, 64, 128, 48, 96, 256};
      pick = int'($urandom_range(5, 0));
      if ($urandom_range(7, 0) == 0) target = GAIN_W'($urandom_range(1023, 16));
      send_frame(sizes[pick], 2, "R2 R3 R6 R7 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule